// File: doc/BRIEF.md
# Protection Region Lookup and Access Checker

This block decides whether a single memory access is allowed. It takes an access address, an access kind (load, store or instruction fetch) and a privilege flag. It also takes the complete configuration of every protection region as flattened vectors. From these it picks the region that covers the address and applies that region's permission code and its no-execute flag. It reports the selected region, a fault when no region covers the address, and a fault when the region forbids the access. It also passes the selected region's memory-type bits through unchanged, so that later logic can decode them.

The path from address to fault is purely combinational, and none of its pins carry a stream. The block therefore has no valid/ready handshake. The caller samples the outputs in the same cycle that it presents an access. A global enable pin turns checking off. When it is low, every output is forced to zero.

A region is described by these fields:
- a base address, bits 31 down to 5;
- a 5-bit size code n, giving a region of 2^(n+1) bytes;
- an enable bit;
- an 8-bit mask that disables subregions;
- a 3-bit permission code and a no-execute bit;
- the memory-type bits type[2:0], C, B and S.

Top module: `mpu_access_checker`

## Requirements
- R1: An enabled region with size code n from 4 to 31 covers the 2^(n+1) bytes that start at its base. Its base is given by `rgn_base` bits [31:5], with the low five bits taken as zero, and is assumed aligned to the size. An address matches the region when its bits n+1 and above equal those of the base. Code 31 covers the whole 4 GB space.
- R2: A region whose size code is 0 to 3 never matches.
- R3: A region whose enable bit is 0 never matches.
- R4: For size codes 7 and above, the region is split into eight equal subregions, numbered k = address bits [n:n-2]. Subregion 0 holds the lowest addresses. When bit k of the region's disable mask is 1, subregion k does not match.
- R5: For size codes 4 to 6, the disable mask is ignored.
- R6: When several regions match, the highest index wins. `hit_idx` gives that index. `attr_type`, `attr_c`, `attr_b` and `attr_s` give that region's fields. With no hit, all of these outputs are 0.
- R7: With checking enabled, an access that no region matches sets `bg_fault`. `hit` and `perm_fault` are 0 in that case.
- R8: The permission codes give these rights:

  | Code | Privileged | User |
  |------|------------|------|
  | 000 | none | none |
  | 001 | read/write | none |
  | 010 | read/write | read-only |
  | 011 | read/write | read/write |
  | 101 | read-only | none |
  | 110 | read-only | read-only |

  A load needs read rights and a store needs write rights; otherwise `perm_fault` is set. `acc_kind` is 00 for a load, 01 for a store, 10 for an instruction fetch, and 11 is treated as a load.
- R9: Permission codes 100 and 111 give no rights in either mode.
- R10: An instruction fetch needs read rights under the permission code and a no-execute bit of 0. Otherwise it sets `perm_fault`.
- R11: When `mpu_en` is 0, `hit`, `hit_idx`, both faults and all attribute outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mpu_en | input | 1 | Global checking enable |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| acc_priv | input | 1 | 1 = privileged access |
| rgn_base | input | NREG*27 | Per-region base bits [31:5]; region i in slice i |
| rgn_size | input | NREG*5 | Per-region size code |
| rgn_en | input | NREG | Per-region enable |
| rgn_subdis | input | NREG*8 | Per-region subregion disable mask |
| rgn_ap | input | NREG*3 | Per-region permission code |
| rgn_xn | input | NREG | Per-region no-execute flag |
| rgn_type | input | NREG*3 | Per-region memory-type bits |
| rgn_c | input | NREG | Per-region C bit |
| rgn_b | input | NREG | Per-region B bit |
| rgn_s | input | NREG | Per-region S bit |
| hit | output | 1 | A region matched |
| hit_idx | output | $clog2(NREG) | Index of the winning region |
| bg_fault | output | 1 | No region covers the address |
| perm_fault | output | 1 | Winning region forbids the access |
| attr_type | output | 3 | Winning region's type bits |
| attr_c | output | 1 | Winning region's C bit |
| attr_b | output | 1 | Winning region's B bit |
| attr_s | output | 1 | Winning region's S bit |

## Verification
The bench probes each boundary where a shift or mask could be off by one.
- Addresses one byte below and one byte above a region's end catch a wrong size exponent, which would wrongly hit or miss.
- A 256-byte region with a single subregion disabled catches a wrong subregion index, which would fault at the neighbouring subregion instead.
- A 128-byte region with its mask set catches a mask wrongly applied to small regions, which would raise spurious background faults.
- Overlapping regions catch a reversed priority, which would report the lower index and its attributes.
- A sweep over every permission code, mode and access kind catches a wrong table row or an ignored no-execute bit.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 5;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int SZ_W     = 5;
  localparam int AP_W     = 3;
  localparam int SUB_N    = 8;
  localparam logic [SZ_W-1:0] SZ_MIN     = 5'd4;
  localparam logic [SZ_W-1:0] SZ_SUB_MIN = 5'd7;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic [2:0] mtype;
    logic       c;
    logic       b;
    logic       s;
  } rgn_attr_t;

  typedef struct packed {
    logic pr;
    logic pw;
    logic ur;
    logic uw;
  } rights_t;

  function automatic rights_t decode_ap(input logic [AP_W-1:0] ap);
    rights_t r;
    r = '0;
    case (ap)
      3'b001: begin r.pr = 1'b1; r.pw = 1'b1; end
      3'b010: begin r.pr = 1'b1; r.pw = 1'b1; r.ur = 1'b1; end
      3'b011: r = 4'b1111;
      3'b101: r.pr = 1'b1;
      3'b110: begin r.pr = 1'b1; r.ur = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mpu_rgn_match.sv
module mpu_rgn_match
  import mpu_chk_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [SZ_W-1:0]   size,
  input  logic              en,
  input  logic [SUB_N-1:0]  subdis,
  output logic              match
);
  logic [ADDR_W-1:0] base_full;
  logic [ADDR_W-1:0] diff;
  logic [SZ_W:0]     upper_sh;
  logic [SZ_W-1:0]   sub_sh;
  logic [ADDR_W-1:0] sub_bits;
  logic              upper_eq;
  logic              size_ok;
  logic              sub_on;
  logic              sub_off;

  always_comb begin
    base_full = {base, {BASE_LSB{1'b0}}};
    diff      = addr ^ base_full;
    upper_sh  = {1'b0, size} + 6'd1;
    upper_eq  = (diff >> upper_sh) == '0;
    size_ok   = size >= SZ_MIN;
    sub_on    = size >= SZ_SUB_MIN;
    sub_sh    = sub_on ? (size - 5'd2) : 5'd0;
    sub_bits  = addr >> sub_sh;
    sub_off   = sub_on && subdis[sub_bits[2:0]];
    match     = en && size_ok && upper_eq && !sub_off;
  end

  // R2 / R3: invalid or disabled regions are never reported as matching
  always_comb begin
    if (!size_ok) a_r2_small_nomatch: assert (!match) else $error("R2 match on small size code");
    if (!en)      a_r3_off_nomatch:   assert (!match) else $error("R3 match on disabled region");
  end
endmodule

// File: rtl/mpu_prio_select.sv
module mpu_prio_select #(
  parameter int NREG = 16,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0] m,
  output logic            any,
  output logic [IW-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (m[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // R6: the chosen region matches and no higher-index region does
  always_comb begin
    if (any) a_r6_top_wins: assert (m[idx] && ((m >> idx) == NREG'(1)))
      else $error("R6 priority pick wrong");
    else a_r7_none: assert (m == '0) else $error("R7 miss with match present");
  end
endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check
  import mpu_chk_pkg::*;
(
  input  logic [AP_W-1:0] ap,
  input  logic            xn,
  input  logic [1:0]      kind,
  input  logic            priv,
  output logic            allow
);
  rights_t   rt;
  logic      can_rd;
  logic      can_wr;
  acc_kind_e k;

  always_comb begin
    rt     = decode_ap(ap);
    k      = acc_kind_e'(kind);
    can_rd = priv ? rt.pr : rt.ur;
    can_wr = priv ? rt.pw : rt.uw;
    case (k)
      ACC_STORE: allow = can_wr;
      ACC_FETCH: allow = can_rd && !xn;
      default:   allow = can_rd;
    endcase
  end

  // R9 / R10
  always_comb begin
    if (ap == 3'b100 || ap == 3'b111)
      a_r9_reserved_deny: assert (!allow) else $error("R9 reserved code allowed");
    if (k == ACC_FETCH && xn)
      a_r10_xn_deny: assert (!allow) else $error("R10 fetch allowed under no-execute");
  end
endmodule

// File: rtl/mpu_access_checker.sv
module mpu_access_checker
  import mpu_chk_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   mpu_en,
  input  logic [31:0]            acc_addr,
  input  logic [1:0]             acc_kind,
  input  logic                   acc_priv,
  input  logic [NREG*BASE_W-1:0] rgn_base,
  input  logic [NREG*SZ_W-1:0]   rgn_size,
  input  logic [NREG-1:0]        rgn_en,
  input  logic [NREG*SUB_N-1:0]  rgn_subdis,
  input  logic [NREG*AP_W-1:0]   rgn_ap,
  input  logic [NREG-1:0]        rgn_xn,
  input  logic [NREG*3-1:0]      rgn_type,
  input  logic [NREG-1:0]        rgn_c,
  input  logic [NREG-1:0]        rgn_b,
  input  logic [NREG-1:0]        rgn_s,
  output logic                   hit,
  output logic [IW-1:0]          hit_idx,
  output logic                   bg_fault,
  output logic                   perm_fault,
  output logic [2:0]             attr_type,
  output logic                   attr_c,
  output logic                   attr_b,
  output logic                   attr_s
);
  logic [NREG-1:0] mvec;
  logic            any;
  logic [IW-1:0]   widx;
  logic [AP_W-1:0] sel_ap;
  logic            sel_xn;
  rgn_attr_t       sel_attr;
  logic            allow;

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    mpu_rgn_match u_match (
      .addr   (acc_addr),
      .base   (rgn_base[g*BASE_W +: BASE_W]),
      .size   (rgn_size[g*SZ_W +: SZ_W]),
      .en     (rgn_en[g]),
      .subdis (rgn_subdis[g*SUB_N +: SUB_N]),
      .match  (mvec[g])
    );
  end

  mpu_prio_select #(.NREG(NREG)) u_sel (
    .m   (mvec),
    .any (any),
    .idx (widx)
  );

  always_comb begin
    sel_ap   = rgn_ap[widx*AP_W +: AP_W];
    sel_xn   = rgn_xn[widx];
    sel_attr = '{mtype: rgn_type[widx*3 +: 3], c: rgn_c[widx], b: rgn_b[widx], s: rgn_s[widx]};
  end

  mpu_perm_check u_perm (
    .ap    (sel_ap),
    .xn    (sel_xn),
    .kind  (acc_kind),
    .priv  (acc_priv),
    .allow (allow)
  );

  always_comb begin
    hit        = mpu_en && any;
    hit_idx    = hit ? widx : '0;
    bg_fault   = mpu_en && !any;
    perm_fault = hit && !allow;
    attr_type  = hit ? sel_attr.mtype : 3'b000;
    attr_c     = hit && sel_attr.c;
    attr_b     = hit && sel_attr.b;
    attr_s     = hit && sel_attr.s;
  end

  // R7 / R10 / R11
  always_comb begin
    if (!mpu_en)
      a_r11_bypass: assert (!hit && !bg_fault && !perm_fault && hit_idx == '0)
        else $error("R11 output while disabled");
    a_r7_bg_exclusive: assert (!(bg_fault && (hit || perm_fault)))
      else $error("R7 background fault with hit");
    if (hit && acc_kind == 2'b10 && rgn_xn[hit_idx])
      a_r10_fetch_fault: assert (perm_fault) else $error("R10 fetch not faulted");
  end
endmodule

// File: tb/sim_mpu_access_checker.sv
module sim_mpu_access_checker;
  localparam int N = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            mpu_en;
  logic [31:0]     acc_addr;
  logic [1:0]      acc_kind;
  logic            acc_priv;
  logic [N*27-1:0] rgn_base;
  logic [N*5-1:0]  rgn_size;
  logic [N-1:0]    rgn_en;
  logic [N*8-1:0]  rgn_subdis;
  logic [N*3-1:0]  rgn_ap;
  logic [N-1:0]    rgn_xn;
  logic [N*3-1:0]  rgn_type;
  logic [N-1:0]    rgn_c, rgn_b, rgn_s;
  logic            hit, bg_fault, perm_fault, attr_c, attr_b, attr_s;
  logic [3:0]      hit_idx;
  logic [2:0]      attr_type;

  mpu_access_checker #(.NREG(N)) u0 (.*);

  logic [31:0] b_base [N];
  logic [4:0]  b_size [N];
  logic        b_en   [N];
  logic [7:0]  b_sd   [N];
  logic [2:0]  b_ap   [N];
  logic        b_xn   [N];
  logic [2:0]  b_ty   [N];
  logic        b_c [N], b_b [N], b_s [N];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  function automatic bit rights(input logic [2:0] ap, input logic pv, input bit wr);
    case (ap)
      3'b001: return pv;
      3'b010: return pv | !wr;
      3'b011: return 1'b1;
      3'b101: return pv & !wr;
      3'b110: return !wr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [12:0] model();
    bit hv = 0;
    int wi = 0;
    logic pf;
    if (!mpu_en) return '0;
    for (int i = 0; i < N; i++) begin
      if (b_en[i] && b_size[i] >= 4) begin
        longint unsigned rs = 64'd1 << (b_size[i] + 1);
        longint unsigned a  = acc_addr;
        longint unsigned lo = b_base[i];
        if (a >= lo && a < lo + rs) begin
          bit ok = 1;
          if (b_size[i] >= 7) begin
            longint unsigned k = (a - lo) / (rs / 8);
            if (b_sd[i][k]) ok = 0;
          end
          if (ok) begin hv = 1; wi = i; end
        end
      end
    end
    if (!hv) return {1'b0, 4'd0, 1'b1, 1'b0, 6'd0};
    if (acc_kind == 2'b01)      pf = !rights(b_ap[wi], acc_priv, 1);
    else if (acc_kind == 2'b10) pf = !rights(b_ap[wi], acc_priv, 0) || b_xn[wi];
    else                        pf = !rights(b_ap[wi], acc_priv, 0);
    return {1'b1, 4'(wi), 1'b0, pf, b_ty[wi], b_c[wi], b_b[wi], b_s[wi]};
  endfunction

  task automatic pack();
    for (int i = 0; i < N; i++) begin
      rgn_base[i*27 +: 27] = b_base[i][31:5];
      rgn_size[i*5 +: 5]   = b_size[i];
      rgn_en[i]            = b_en[i];
      rgn_subdis[i*8 +: 8] = b_sd[i];
      rgn_ap[i*3 +: 3]     = b_ap[i];
      rgn_xn[i]            = b_xn[i];
      rgn_type[i*3 +: 3]   = b_ty[i];
      rgn_c[i] = b_c[i]; rgn_b[i] = b_b[i]; rgn_s[i] = b_s[i];
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      b_base[i] = 0; b_size[i] = 0; b_en[i] = 0; b_sd[i] = 0; b_ap[i] = 0;
      b_xn[i] = 0; b_ty[i] = 0; b_c[i] = 0; b_b[i] = 0; b_s[i] = 0;
    end
  endtask

  task automatic setr(input int i, input logic [31:0] base, input logic [4:0] sz,
                      input logic [7:0] sd, input logic [2:0] ap, input logic xn,
                      input logic [5:0] at);
    b_base[i] = base; b_size[i] = sz; b_en[i] = 1; b_sd[i] = sd; b_ap[i] = ap;
    b_xn[i] = xn; {b_ty[i], b_c[i], b_b[i], b_s[i]} = at;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [1:0] k,
                       input logic pv);
    logic [12:0] exp, act;
    @(posedge clk);
    pack();
    acc_addr = a; acc_kind = k; acc_priv = pv;
    @(negedge clk);
    exp = model();
    act = {hit, hit_idx, bg_fault, perm_fault, attr_type, attr_c, attr_b, attr_s};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h kind=%0d priv=%0d actual=%b expected=%b", tag, a, k, pv, act, exp);
    end
  endtask

  task automatic probe_vec(input string tag, input logic [31:0] a, input logic [12:0] want);
    logic [12:0] act;
    @(posedge clk);
    pack();
    acc_addr = a; acc_kind = 2'b00; acc_priv = 1'b1;
    @(negedge clk);
    act = {hit, hit_idx, bg_fault, perm_fault, attr_type, attr_c, attr_b, attr_s};
    total++;
    if (act !== want) begin
      bad++;
      $display("FAIL %s addr=%h actual=%b expected=%b", tag, a, act, want);
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mpu_en = 0; acc_addr = 0; acc_kind = 0; acc_priv = 0;
    clear_all();
    pack();

    // R11: disabled checking zeroes everything even with a covering region
    setr(3, 32'h0, 5'd31, 8'h00, 3'b000, 1'b1, 6'b111111);
    probe_vec("R11 bypass", 32'h1234_5678, 13'd0);
    mpu_en = 1;
    // R1: 4 GB region, permission code 000 -> fault
    probe_vec("R1 whole space", 32'hFFFF_FFFC, {1'b1, 4'd3, 1'b0, 1'b1, 6'b111111});
    clear_all();
    // R1 edges: 64-byte region (code 5) at 0x1000
    setr(2, 32'h1000, 5'd5, 8'h00, 3'b011, 1'b0, 6'b010100);
    probe_vec("R1 lowest byte", 32'h1000, {1'b1, 4'd2, 1'b0, 1'b0, 6'b010100});
    probe_vec("R1 last byte", 32'h103F, {1'b1, 4'd2, 1'b0, 1'b0, 6'b010100});
    probe_vec("R7 one past end", 32'h1040, {1'b0, 4'd0, 1'b1, 1'b0, 6'd0});
    probe_vec("R7 one below", 32'h0FFF, {1'b0, 4'd0, 1'b1, 1'b0, 6'd0});
    // R2: size code 3 never matches
    clear_all();
    setr(1, 32'h2000, 5'd3, 8'h00, 3'b011, 1'b0, 6'b000001);
    probe_vec("R2 small code", 32'h2000, {1'b0, 4'd0, 1'b1, 1'b0, 6'd0});
    // R3: disabled region
    setr(1, 32'h2000, 5'd8, 8'h00, 3'b011, 1'b0, 6'b000001);
    b_en[1] = 0;
    probe_vec("R3 disabled", 32'h2010, {1'b0, 4'd0, 1'b1, 1'b0, 6'd0});
    // R4: 256-byte region, subregion 3 (0x60..0x7F) disabled
    clear_all();
    setr(4, 32'h3000, 5'd7, 8'b0000_1000, 3'b011, 1'b0, 6'b001000);
    probe_vec("R4 sub3 off", 32'h3060, {1'b0, 4'd0, 1'b1, 1'b0, 6'd0});
    probe_vec("R4 sub3 top", 32'h307F, {1'b0, 4'd0, 1'b1, 1'b0, 6'd0});
    probe_vec("R4 sub4 on", 32'h3080, {1'b1, 4'd4, 1'b0, 1'b0, 6'b001000});
    probe_vec("R4 sub2 on", 32'h305F, {1'b1, 4'd4, 1'b0, 1'b0, 6'b001000});
    // R4: subregion 0 is the lowest, in a 1 MB region (code 19)
    setr(4, 32'h0010_0000, 5'd19, 8'b0000_0001, 3'b011, 1'b0, 6'b001000);
    probe_vec("R4 sub0 low", 32'h0010_0004, {1'b0, 4'd0, 1'b1, 1'b0, 6'd0});
    probe_vec("R4 sub7 high", 32'h001F_FFF0, {1'b1, 4'd4, 1'b0, 1'b0, 6'b001000});
    // R5: 128-byte region ignores its mask
    clear_all();
    setr(6, 32'h4000, 5'd6, 8'hFF, 3'b011, 1'b0, 6'b100110);
    probe_vec("R5 mask ignored", 32'h4044, {1'b1, 4'd6, 1'b0, 1'b0, 6'b100110});
    // R6: overlap, higher index wins and supplies attributes
    setr(9, 32'h4000, 5'd10, 8'h00, 3'b000, 1'b0, 6'b011011);
    probe_vec("R6 higher wins", 32'h4044, {1'b1, 4'd9, 1'b0, 1'b1, 6'b011011});
    probe_vec("R6 outer only", 32'h4400, {1'b1, 4'd9, 1'b0, 1'b1, 6'b011011});
    // R8 R9 R10: sweep every code, mode and kind
    clear_all();
    for (int ap = 0; ap < 8; ap++)
      for (int xn = 0; xn < 2; xn++)
        for (int pv = 0; pv < 2; pv++)
          for (int k = 0; k < 4; k++) begin
            setr(0, 32'h0, 5'd31, 8'h00, 3'(ap), 1'(xn), 6'b000000);
            probe("R8 R9 R10 sweep", 32'h8000_0000, 2'(k), 1'(pv));
          end
    // R1 R4 R6 R8 R10: random configurations against the model
    for (int t = 0; t < 400; t++) begin
      clear_all();
      for (int i = 0; i < N; i++) begin
        logic [4:0] sz = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(0, 31))
                                                     : 5'($urandom_range(4, 14));
        logic [31:0] msk = (sz >= 31) ? 32'h0 : ~((32'h1 << (sz + 1)) - 1);
        b_en[i] = ($urandom_range(0, 3) != 0);
        b_size[i] = sz;
        b_base[i] = {16'h0, 16'($urandom_range(0, 16'hFFFF))} & msk;
        b_sd[i] = ($urandom_range(0, 1) == 1) ? 8'($urandom) : 8'h00;
        b_ap[i] = 3'($urandom); b_xn[i] = 1'($urandom);
        b_ty[i] = 3'($urandom); b_c[i] = 1'($urandom);
        b_b[i] = 1'($urandom); b_s[i] = 1'($urandom);
      end
      for (int j = 0; j < 8; j++) begin
        int r = $urandom_range(0, N - 1);
        logic [31:0] a = ($urandom_range(0, 7) == 0) ? $urandom
                        : b_base[r] + 32'($urandom_range(0, 8191));
        probe("R1 R4 R6 R8 R10 random", a, 2'($urandom), 1'($urandom));
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule